// File: doc/BRIEF.md
# Descriptor Ring Packet DMA

This block moves Ethernet frames between a MAC byte stream and packet buffers in memory. Two circular rings of descriptors steer the traffic, one ring for transmit and one for receive. Every descriptor is two 32-bit words: the first carries a 16-bit status in its upper half and a 16-bit byte count in its lower half, the second carries the word-aligned buffer address. Ownership passes between software and the engine through the top status bit, and a wrap bit marks the last descriptor of a ring.

Software supplies each ring's base address, releases a halted engine with a one-cycle clear-halt pulse, and may hold a graceful-stop request on either direction. The engine reports through five sticky event bits that software clears by writing ones. Each direction has its own word-wide memory port with a fixed one-cycle read latency. The transmit side drives a byte stream with a last marker and honours backpressure. The receive side accepts a byte stream with a last marker and an error flag.

Top module: `ring_dma`

## Requirements
- R1: After reset both engines are halted, all five event bits are 0, tx_valid is 0 and rx_ready is 0; each engine starts at its ring base.
- R2: Descriptor i of a ring sits at base + 8*i; word 0 holds status in bits 31:16 and length in bits 15:0, word 1 holds the buffer address. Buffer byte k is in the word at address + 4*(k/4), bits 8*(k%4)+7 down to 8*(k%4).
- R3: A transmit descriptor whose status bit 15 (ready) is set is sent byte by byte in buffer order, with tx_last only on the final byte. tx_data and tx_valid stay stable while tx_ready is low. Word 0 is then rewritten with bit 15 cleared and the other status bits and length unchanged, and event bit 0 is set.
- R4: A receive descriptor whose status bit 15 (empty) is set takes the next frame. Word 0 is rewritten with bit 15 cleared, the length set to the bytes stored (FCS included), bit 13 kept, and bit 0 equal to rx_err seen with the last byte. Event bit 1 is set.
- R5: A received frame longer than MAX_RX_LEN bytes keeps only its first MAX_RX_LEN bytes and reports that length with status bit 1 (overrun) set. No memory word past the truncated data is written.
- R6: After a descriptor with status bit 13 (wrap) the next descriptor fetched is at the ring base; otherwise it is the one 8 bytes further on.
- R7: The transmit engine halts, with tx_halted high, when it fetches a descriptor without the ready bit. It sends nothing more until a tx_clr_halt pulse, and then it re-reads that same descriptor.
- R8: The receive engine that fetches a descriptor without the empty bit sets event bit 2 (busy) and halts with rx_ready low. rx_clr_halt is ignored while bit 2 is set. After the bit is cleared, a pulse resumes at that same descriptor.
- R9: While tx_gstop (rx_gstop) is held, the engine finishes the frame in progress, sets event bit 3 (bit 4), and fetches no further descriptor. Dropping the request resumes the ring.
- R10: Writing ev_clr clears exactly the event bits given as ones and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_base | input | 32 | Transmit ring base address |
| rx_base | input | 32 | Receive ring base address |
| tx_clr_halt | input | 1 | Pulse: release the halted transmit engine |
| rx_clr_halt | input | 1 | Pulse: release the halted receive engine |
| tx_gstop | input | 1 | Graceful transmit stop request (level) |
| rx_gstop | input | 1 | Graceful receive stop request (level) |
| ev_clr | input | 5 | Write-one-to-clear mask for the event bits |
| ev | output | 5 | Events: 0 tx frame, 1 rx frame, 2 rx busy, 3 tx stopped, 4 rx stopped |
| tx_halted | output | 1 | Transmit engine halted |
| rx_halted | output | 1 | Receive engine halted |
| txm_req | output | 1 | Transmit memory request |
| txm_we | output | 1 | Transmit memory write enable |
| txm_addr | output | 32 | Transmit memory byte address (word aligned) |
| txm_wdata | output | 32 | Transmit memory write data |
| txm_rdata | input | 32 | Transmit memory read data, one cycle after the request |
| rxm_req | output | 1 | Receive memory request |
| rxm_we | output | 1 | Receive memory write enable |
| rxm_addr | output | 32 | Receive memory byte address (word aligned) |
| rxm_wdata | output | 32 | Receive memory write data |
| rxm_rdata | input | 32 | Receive memory read data, one cycle after the request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_err | input | 1 | Frame error, meaningful with rx_last |
| rx_ready | output | 1 | Engine accepts a receive byte |

## Verification
The bench sweeps transmit lengths from 1 to 12 and receive lengths from 1 to 22 around three-entry rings with a small receive limit. Each wrap lands on the base, and a poisoned fourth transmit descriptor exposes an engine that steps past the wrap. Lengths that are not a multiple of four, and receive frames that end exactly at, just below or beyond the limit, catch wrong byte lanes, an off-by-one length or a write past the truncated buffer. Stalled transmit handshakes catch a stream that moves without tx_ready. The halt corners are checked at the ports: a receiver that resumes while busy is still pending, or that skips the descriptor it missed on, shows up there, and so does a graceful stop that cuts a frame short or fetches the next descriptor.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int LEN_W = 16;
  localparam int ST_W  = 16;
  localparam int N_EV  = 5;

  // status bit positions inside the 16-bit status half-word
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_INT  = 12;
  localparam int ST_LAST = 11;
  localparam int ST_CRC  = 10;
  localparam int ST_OVR  = 1;
  localparam int ST_ERR  = 0;

  localparam logic [AW-1:0] DESC_BYTES = AW'(8);

  // event bit positions
  localparam int EV_TXF  = 0;
  localparam int EV_RXF  = 1;
  localparam int EV_BUSY = 2;
  localparam int EV_TXS  = 3;
  localparam int EV_RXS  = 4;

  typedef enum logic [3:0] {
    T_HALT, T_RD0, T_W0, T_RD1, T_W1, T_LDW, T_WTW, T_SEND, T_WB, T_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    R_HALT, R_RD0, R_W0, R_RD1, R_W1, R_DATA, R_WB, R_STOP
  } rx_state_e;

  // ring offset of the descriptor after the current one
  function automatic logic [AW-1:0] next_off(input logic [AW-1:0] off, input logic wrap);
    return wrap ? '0 : off + DESC_BYTES;
  endfunction

  // word address holding buffer byte cnt
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] ptr, input logic [LEN_W-1:0] cnt);
    return ptr + AW'({cnt[LEN_W-1:2], 2'b00});
  endfunction

  function automatic logic [7:0] pick_byte(input logic [DW-1:0] w, input logic [1:0] lane);
    logic [DW-1:0] s;
    s = w >> (8 * lane);
    return s[7:0];
  endfunction

  // lane 0 starts a fresh word; other lanes merge into the bytes held so far
  function automatic logic [DW-1:0] put_byte(input logic [DW-1:0] w, input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [DW-1:0] base;
    logic [DW-1:0] m;
    base = (lane == 2'd0) ? '0 : w;
    m    = DW'(32'hFF) << (8 * lane);
    return (base & ~m) | (DW'(b) << (8 * lane));
  endfunction

  function automatic logic [ST_W-1:0] rx_status(input logic wrap, input logic ovr, input logic err);
    logic [ST_W-1:0] s;
    s          = '0;
    s[ST_WRAP] = wrap;
    s[ST_OVR]  = ovr;
    s[ST_ERR]  = err;
    return s;
  endfunction

endpackage

// File: rtl/ring_evt.sv
module ring_evt #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10: a raised event is visible next cycle, even against a clear
    p_set_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    // R10: a clear without a set drops the bit
    p_clr_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
  end

endmodule

// File: rtl/ring_tx_engine.sv
module ring_tx_engine
  import ring_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          clr_halt,
  input  logic          gstop,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          halted,
  output logic          ev_frame,
  output logic          ev_stop
);

  tx_state_e        state;
  logic [AW-1:0]    off;
  logic [ST_W-1:0]  st;
  logic [LEN_W-1:0] len;
  logic [AW-1:0]    ptr;
  logic [LEN_W-1:0] cnt;
  logic [DW-1:0]    word;

  // named internal events
  logic fetch_miss;
  logic wb_fire;
  logic is_last;

  assign is_last    = (cnt + LEN_W'(1)) >= len;
  assign fetch_miss = (state == T_W0) && !m_rdata[16 + ST_OWN];
  assign wb_fire    = (state == T_WB);
  assign ev_frame   = wb_fire;
  assign ev_stop    = (state == T_RD0) && gstop;
  assign halted     = (state == T_HALT);

  always_comb begin
    m_req    = 1'b0;
    m_we     = 1'b0;
    m_addr   = base + off;
    m_wdata  = '0;
    tx_valid = 1'b0;
    tx_data  = pick_byte(word, cnt[1:0]);
    tx_last  = 1'b0;
    case (state)
      T_RD0:  m_req = !gstop;
      T_RD1:  begin m_req = 1'b1; m_addr = base + off + AW'(4); end
      T_LDW:  begin m_req = 1'b1; m_addr = word_addr(ptr, cnt); end
      T_SEND: begin tx_valid = 1'b1; tx_last = is_last; end
      T_WB: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_wdata = {st & ~(ST_W'(1) << ST_OWN), len};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= T_HALT;
      off   <= '0;
      st    <= '0;
      len   <= '0;
      ptr   <= '0;
      cnt   <= '0;
      word  <= '0;
    end else begin
      case (state)
        T_HALT: if (clr_halt) state <= T_RD0;
        T_RD0:  state <= gstop ? T_STOP : T_W0;
        T_W0: begin
          st    <= m_rdata[DW-1:16];
          len   <= m_rdata[LEN_W-1:0];
          state <= fetch_miss ? T_HALT : T_RD1;
        end
        T_RD1:  state <= T_W1;
        T_W1: begin
          ptr   <= m_rdata;
          cnt   <= '0;
          state <= T_LDW;
        end
        T_LDW:  state <= T_WTW;
        T_WTW: begin
          word  <= m_rdata;
          state <= T_SEND;
        end
        T_SEND: if (tx_ready) begin
          if (is_last) state <= T_WB;
          else begin
            cnt <= cnt + LEN_W'(1);
            if (cnt[1:0] == 2'd3) state <= T_LDW;
          end
        end
        T_WB: begin
          off   <= next_off(off, st[ST_WRAP]);
          state <= T_RD0;
        end
        T_STOP: if (!gstop) state <= T_RD0;
        default: state <= T_HALT;
      endcase
    end
  end

  // R7: a descriptor not owned by the engine halts it
  p_halt_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_miss |=> halted);
  // R3: the only descriptor write hands ownership back
  p_wb_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> !m_wdata[16 + ST_OWN]);
  // R3: a stalled byte is held steady
  p_stream_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R6: a wrapped descriptor sends the ring back to its base
  p_wrap_to_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && st[ST_WRAP]) |=> (off == '0));
  // R9: a graceful stop leaves the stream and memory quiet
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!tx_valid && !m_req));

endmodule

// File: rtl/ring_rx_engine.sv
module ring_rx_engine
  import ring_dma_pkg::*;
#(
  parameter int MAX_LEN = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          clr_halt,
  input  logic          busy_pend,
  input  logic          gstop,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          rx_ready,
  output logic          halted,
  output logic          ev_frame,
  output logic          ev_busy,
  output logic          ev_stop
);

  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

  rx_state_e        state;
  logic [AW-1:0]    off;
  logic             wrap;
  logic [AW-1:0]    ptr;
  logic [LEN_W-1:0] cnt;
  logic [DW-1:0]    word;
  logic             ovr;
  logic             err;

  // named internal events
  logic accept;
  logic store;
  logic wb_fire;
  logic [DW-1:0] merged;
  logic unused_bits;

  assign unused_bits = ^{m_rdata[DW-2], m_rdata[DW-4:0]};
  assign rx_ready = (state == R_DATA);
  assign accept   = rx_valid && rx_ready;
  assign store    = accept && (cnt < LIMIT);
  assign merged   = put_byte(word, cnt[1:0], rx_data);
  assign wb_fire  = (state == R_WB);
  assign ev_frame = wb_fire;
  assign ev_busy  = (state == R_W0) && !m_rdata[16 + ST_OWN];
  assign ev_stop  = (state == R_RD0) && gstop;
  assign halted   = (state == R_HALT);

  always_comb begin
    m_req   = 1'b0;
    m_we    = 1'b0;
    m_addr  = base + off;
    m_wdata = '0;
    case (state)
      R_RD0: m_req = !gstop;
      R_RD1: begin m_req = 1'b1; m_addr = base + off + AW'(4); end
      R_DATA: if (store) begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_addr  = word_addr(ptr, cnt);
        m_wdata = merged;
      end
      R_WB: begin
        m_req   = 1'b1;
        m_we    = 1'b1;
        m_wdata = {rx_status(wrap, ovr, err), cnt};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= R_HALT;
      off   <= '0;
      wrap  <= 1'b0;
      ptr   <= '0;
      cnt   <= '0;
      word  <= '0;
      ovr   <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (state)
        R_HALT: if (clr_halt && !busy_pend) state <= R_RD0;
        R_RD0:  state <= gstop ? R_STOP : R_W0;
        R_W0: begin
          wrap  <= m_rdata[16 + ST_WRAP];
          state <= ev_busy ? R_HALT : R_RD1;
        end
        R_RD1:  state <= R_W1;
        R_W1: begin
          ptr   <= m_rdata;
          cnt   <= '0;
          ovr   <= 1'b0;
          err   <= 1'b0;
          state <= R_DATA;
        end
        R_DATA: if (accept) begin
          if (store) begin
            word <= merged;
            cnt  <= cnt + LEN_W'(1);
          end else begin
            ovr  <= 1'b1;
          end
          if (rx_last) begin
            err   <= rx_err;
            state <= R_WB;
          end
        end
        R_WB: begin
          off   <= next_off(off, wrap);
          state <= R_RD0;
        end
        R_STOP: if (!gstop) state <= R_RD0;
        default: state <= R_HALT;
      endcase
    end
  end

  // R8: a missed descriptor halts reception and closes the stream
  p_busy_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |=> (halted && !rx_ready));
  // R8: a pending busy event keeps the engine halted
  p_resume_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && busy_pend) |=> halted);
  // R5: a reported length never exceeds the buffer limit
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (m_wdata[LEN_W-1:0] <= LIMIT));
  // R4: the header write returns the descriptor to software
  p_give_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !m_wdata[16 + ST_OWN]);
  // R6: a wrapped descriptor sends the ring back to its base
  p_wrap_to_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && wrap) |=> (off == '0));

endmodule

// File: rtl/ring_dma.sv
module ring_dma
  import ring_dma_pkg::*;
#(
  parameter int MAX_RX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     tx_base,
  input  logic [AW-1:0]     rx_base,
  input  logic              tx_clr_halt,
  input  logic              rx_clr_halt,
  input  logic              tx_gstop,
  input  logic              rx_gstop,
  input  logic [N_EV-1:0]   ev_clr,
  output logic [N_EV-1:0]   ev,
  output logic              tx_halted,
  output logic              rx_halted,
  output logic              txm_req,
  output logic              txm_we,
  output logic [AW-1:0]     txm_addr,
  output logic [DW-1:0]     txm_wdata,
  input  logic [DW-1:0]     txm_rdata,
  output logic              rxm_req,
  output logic              rxm_we,
  output logic [AW-1:0]     rxm_addr,
  output logic [DW-1:0]     rxm_wdata,
  input  logic [DW-1:0]     rxm_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              rx_ready
);

  logic tx_frame_ev, tx_stop_ev;
  logic rx_frame_ev, rx_busy_ev, rx_stop_ev;
  logic [N_EV-1:0] ev_set;

  ring_tx_engine u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (tx_base),
    .clr_halt (tx_clr_halt),
    .gstop    (tx_gstop),
    .m_req    (txm_req),
    .m_we     (txm_we),
    .m_addr   (txm_addr),
    .m_wdata  (txm_wdata),
    .m_rdata  (txm_rdata),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .halted   (tx_halted),
    .ev_frame (tx_frame_ev),
    .ev_stop  (tx_stop_ev)
  );

  ring_rx_engine #(.MAX_LEN(MAX_RX_LEN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (rx_base),
    .clr_halt  (rx_clr_halt),
    .busy_pend (ev[EV_BUSY]),
    .gstop     (rx_gstop),
    .m_req     (rxm_req),
    .m_we      (rxm_we),
    .m_addr    (rxm_addr),
    .m_wdata   (rxm_wdata),
    .m_rdata   (rxm_rdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .rx_err    (rx_err),
    .rx_ready  (rx_ready),
    .halted    (rx_halted),
    .ev_frame  (rx_frame_ev),
    .ev_busy   (rx_busy_ev),
    .ev_stop   (rx_stop_ev)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_TXF]  = tx_frame_ev;
    ev_set[EV_RXF]  = rx_frame_ev;
    ev_set[EV_BUSY] = rx_busy_ev;
    ev_set[EV_TXS]  = tx_stop_ev;
    ev_set[EV_RXS]  = rx_stop_ev;
  end

  ring_evt #(.N(N_EV)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_set),
    .clr   (ev_clr),
    .q     (ev)
  );

  // R1: nothing moves on either stream while its engine is halted
  p_halted_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halted |-> !tx_valid) and (rx_halted |-> !rx_ready));

endmodule

// File: tb/ring_dma_test.sv
module ring_dma_test;

  localparam int MAXL = 18;
  localparam logic [31:0] TXB   = 32'h100;
  localparam logic [31:0] RXB   = 32'h200;
  localparam logic [31:0] TXBUF = 32'h400;
  localparam logic [31:0] RXBUF = 32'h800;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        tx_clr_halt = 1'b0, rx_clr_halt = 1'b0;
  logic        tx_gstop = 1'b0, rx_gstop = 1'b0;
  logic [4:0]  ev_clr = '0;
  logic [4:0]  ev;
  logic        tx_halted, rx_halted;
  logic        txm_req, txm_we, rxm_req, rxm_we;
  logic [31:0] txm_addr, txm_wdata, rxm_addr, rxm_wdata;
  logic [31:0] txm_rdata = '0, rxm_rdata = '0;
  logic        tx_valid, tx_last, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;

  ring_dma #(.MAX_RX_LEN(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .tx_base(TXB), .rx_base(RXB),
    .tx_clr_halt(tx_clr_halt), .rx_clr_halt(rx_clr_halt),
    .tx_gstop(tx_gstop), .rx_gstop(rx_gstop), .ev_clr(ev_clr), .ev(ev),
    .tx_halted(tx_halted), .rx_halted(rx_halted),
    .txm_req(txm_req), .txm_we(txm_we), .txm_addr(txm_addr),
    .txm_wdata(txm_wdata), .txm_rdata(txm_rdata),
    .rxm_req(rxm_req), .rxm_we(rxm_we), .rxm_addr(rxm_addr),
    .rxm_wdata(rxm_wdata), .rxm_rdata(rxm_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready)
  );

  // memory model: one array, both ports plus a bench poke port
  logic [31:0] mem [0:1023];
  logic        pk_en = 1'b0;
  logic [31:0] pk_a = '0, pk_d = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      if (pk_en) mem[pk_a[11:2]] <= pk_d;
      if (txm_req) begin
        if (txm_we) mem[txm_addr[11:2]] <= txm_wdata;
        else        txm_rdata <= mem[txm_addr[11:2]];
      end
      if (rxm_req) begin
        if (rxm_we) mem[rxm_addr[11:2]] <= rxm_wdata;
        else        rxm_rdata <= mem[rxm_addr[11:2]];
      end
    end
  end

  // transmit capture
  logic [7:0] cap [0:1023];
  logic       caplast [0:1023];
  int         cap_n = 0;
  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      cap[cap_n]     <= tx_data;
      caplast[cap_n] <= tx_last;
      cap_n          <= cap_n + 1;
    end
  end

  // transmit backpressure pattern
  bit stall_mode = 1'b0;
  int tick = 0;
  always @(negedge clk) begin
    tick     <= tick + 1;
    tx_ready <= !stall_mode || (tick % 3 != 1);
  end

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int k);
    return 8'((f * 37 + k * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]] >> (8 * a[1:0]);
    return w[7:0];
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    pk_en = 1'b1; pk_a = a; pk_d = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic pulse_tx;
    tx_clr_halt = 1'b1; @(negedge clk); tx_clr_halt = 1'b0;
  endtask

  task automatic pulse_rx;
    rx_clr_halt = 1'b1; @(negedge clk); rx_clr_halt = 1'b0;
  endtask

  task automatic clear_ev(input logic [4:0] m);
    ev_clr = m; @(negedge clk); ev_clr = '0;
  endtask

  task automatic wait_owner_clear(input logic [31:0] a);
    int n = 0;
    while (mem[a[11:2]][31] && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  // transmit descriptor idx: length L, data pattern f; wrap on idx 2 (R2, R6)
  task automatic arm_tx(input int idx, input int L, input int f);
    logic [31:0] buf_a, w;
    logic [15:0] s;
    buf_a = TXBUF + 32'(idx * 64);
    for (int k = 0; k < L; k += 4) begin
      w = {pat(f, k + 3), pat(f, k + 2), pat(f, k + 1), pat(f, k)};
      poke(buf_a + 32'(k), w);
    end
    s = 16'h9C00 | ((idx == 2) ? 16'h2000 : 16'h0000);
    poke(TXB + 32'(idx * 8) + 4, buf_a);
    poke(TXB + 32'(idx * 8), {s, 16'(L)});
  endtask

  task automatic check_tx_frame(input string req, input int start, input int L, input int f);
    int bad = 0;
    for (int k = 0; k < L; k++) begin
      if (cap[start + k] !== pat(f, k)) bad++;
      if (caplast[start + k] !== (k == L - 1)) bad++;
    end
    eq(req, 32'(bad), 32'd0);
  endtask

  // receive descriptor idx: empty, wrap on idx 2, buffer filled with sentinels
  task automatic arm_rx(input int idx);
    logic [31:0] buf_a;
    buf_a = RXBUF + 32'(idx * 64);
    for (int w = 0; w < 7; w++) poke(buf_a + 32'(4 * w), 32'hC0DE_0000 + 32'(w));
    poke(RXB + 32'(idx * 8) + 4, buf_a);
    poke(RXB + 32'(idx * 8), {(idx == 2) ? 16'hA000 : 16'h8000, 16'h0});
  endtask

  task automatic send_rx(input int L, input int f, input bit e);
    for (int k = 0; k < L; k++) begin
      rx_valid = 1'b1;
      rx_data  = pat(f, k);
      rx_last  = (k == L - 1);
      rx_err   = (k == L - 1) && e;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int idx;
    int start;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    eq("R1 tx_halted", 32'(tx_halted), 32'd1);
    eq("R1 rx_halted", 32'(rx_halted), 32'd1);
    eq("R1 events", 32'(ev), 32'd0);
    eq("R1 tx_valid/rx_ready", {30'd0, tx_valid, rx_ready}, 32'd0);

    // poison a fourth transmit descriptor: reached only if wrap is ignored (R6)
    poke(TXBUF + 32'(3 * 64), 32'hFFFF_FFFF);
    poke(TXB + 24 + 4, TXBUF + 32'(3 * 64));
    poke(TXB + 24, {16'h9C00, 16'd4});

    // ---------------- transmit length sweep ----------------
    idx = 0;
    for (int L = 1; L <= 12; L++) begin
      start = cap_n;
      arm_tx(idx, L, L);
      stall_mode = (L % 3 == 0);
      repeat (10) @(negedge clk);
      eq("R7 no send while halted", 32'(cap_n - start), 32'd0);
      eq("R7 halted before release", 32'(tx_halted), 32'd1);
      pulse_tx();
      wait_owner_clear(TXB + 32'(idx * 8));
      repeat (8) @(negedge clk);
      eq("R3 byte count", 32'(cap_n - start), 32'(L));
      check_tx_frame("R3 R2 R6 bytes and last", start, L, L);
      eq("R3 writeback",
         mem[(TXB[11:2]) + 10'(idx * 2)],
         {((idx == 2) ? 16'h3C00 : 16'h1C00), 16'(L)});
      eq("R3 tx frame event", 32'(ev[0]), 32'd1);
      eq("R7 halted on next", 32'(tx_halted), 32'd1);
      clear_ev(5'b00001);
      eq("R10 clear bit0 only", 32'(ev), 32'd0);
      idx = (idx + 1) % 3;
    end
    stall_mode = 1'b0;

    // ---------------- receive length sweep ----------------
    idx = 0;
    for (int L = 1; L <= 22; L++) begin
      int stored;
      bit e;
      logic [15:0] exp_st;
      stored = (L > MAXL) ? MAXL : L;
      e = (L % 5 == 0);
      arm_rx(idx);
      if (L > 1) begin
        eq("R8 busy event", 32'(ev[2]), 32'd1);
        eq("R8 halted with stream closed", {30'd0, rx_halted, rx_ready}, 32'd2);
        if (L == 2) begin
          pulse_rx();
          repeat (6) @(negedge clk);
          eq("R8 clear-halt ignored while busy", 32'(rx_halted), 32'd1);
        end
        clear_ev(5'b00100);
        eq("R10 bit2 cleared, bit1 kept", 32'(ev), 32'h2);
        clear_ev(5'b00010);
        eq("R10 bit1 cleared", 32'(ev), 32'h0);
      end
      pulse_rx();
      send_rx(L, 100 + L, e);
      wait_owner_clear(RXB + 32'(idx * 8));
      exp_st = ((idx == 2) ? 16'h2000 : 16'h0) | ((L > MAXL) ? 16'h2 : 16'h0) | (e ? 16'h1 : 16'h0);
      eq("R4 R5 status and length", mem[(RXB[11:2]) + 10'(idx * 2)], {exp_st, 16'(stored)});
      begin
        int bad = 0;
        for (int k = 0; k < stored; k++)
          if (mbyte(RXBUF + 32'(idx * 64 + k)) !== pat(100 + L, k)) bad++;
        eq("R4 R2 stored bytes", 32'(bad), 32'd0);
      end
      eq("R5 no write past buffer limit",
         mem[(RXBUF[11:2]) + 10'(idx * 16 + 5)], 32'hC0DE_0005);
      eq("R4 rx frame event", 32'(ev[1]), 32'd1);
      idx = (idx + 1) % 3;   // R6: idx 2 wraps to 0
    end

    // ---------------- graceful transmit stop ----------------
    clear_ev(5'b11111);
    begin
      int i0, i1;
      i0 = 0; i1 = 1;   // 12 frames over a 3-entry ring leave the index at 0
      start = cap_n;
      arm_tx(i0, 10, 200);
      arm_tx(i1, 10, 201);
      pulse_tx();
      while (cap_n == start) @(negedge clk);
      tx_gstop = 1'b1;
      wait_owner_clear(TXB + 32'(i0 * 8));
      repeat (20) @(negedge clk);
      eq("R9 tx frame completed", 32'(cap_n - start), 32'd10);
      check_tx_frame("R9 tx frame intact", start, 10, 200);
      eq("R9 tx stop event", 32'(ev[3]), 32'd1);
      eq("R9 next tx descriptor untouched", 32'(mem[(TXB[11:2]) + 10'(i1 * 2)][31]), 32'd1);
      tx_gstop = 1'b0;
      wait_owner_clear(TXB + 32'(i1 * 8));
      repeat (6) @(negedge clk);
      eq("R9 tx resumes", 32'(cap_n - start), 32'd20);
      check_tx_frame("R9 resumed frame", start + 10, 10, 201);
    end

    // ---------------- graceful receive stop ----------------
    begin
      int i0, i1;
      i0 = 22 % 3; i1 = (i0 + 1) % 3;
      arm_rx(i0);
      arm_rx(i1);
      clear_ev(5'b11111);
      pulse_rx();
      while (!rx_ready) @(negedge clk);
      rx_gstop = 1'b1;
      send_rx(8, 300, 1'b0);
      wait_owner_clear(RXB + 32'(i0 * 8));
      repeat (10) @(negedge clk);
      eq("R9 rx frame completed", mem[(RXB[11:2]) + 10'(i0 * 2)], 32'h0000_0008);
      eq("R9 rx stop event", 32'(ev[4]), 32'd1);
      eq("R9 rx stream closed", 32'(rx_ready), 32'd0);
      eq("R9 next rx descriptor untouched", 32'(mem[(RXB[11:2]) + 10'(i1 * 2)][31]), 32'd1);
      rx_gstop = 1'b0;
      send_rx(6, 301, 1'b0);
      wait_owner_clear(RXB + 32'(i1 * 8));
      eq("R9 rx resumes in next descriptor", mem[(RXB[11:2]) + 10'(i1 * 2)],
         {((i1 == 2) ? 16'h2000 : 16'h0), 16'd6});
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule